// File: doc/BRIEF.md
# Replace-Only Register-Row Max Priority Queue

This block is a maximum-first priority queue held in a single row of key registers. Its one operation is a replace. In a single accepted request, the key at the head of the row leaves the queue and the new key enters it. The row is then reordered in the same clock cycle by two waves of neighbour compare-and-swap, so a new replace can be issued on every cycle.

Filling and draining both use replace. Reset loads every slot with the all-ones key, which acts as plus infinity, so the first replaces simply push these sentinels out. A replace that carries the all-zeros key acts as a dequeue, because zero is minus infinity for unsigned keys. The removed key comes out of a register one cycle after the request, marked by an output strobe.

Top module: `replace_pq`

## Requirements
- R1: While `rst` is high at a rising edge, every slot is loaded with the all-ones key and `top_valid` is cleared. In the cycle after reset, `top_valid` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. On the next cycle, `top_valid` is 1 and `top_key` holds the key that was at the head before the request.
- R3: `req_ready` is 1 whenever `rst` is 0. Requests on consecutive cycles are each accepted, and each one produces a result on the following cycle.
- R4: After reset, the first DEPTH accepted replaces each return the all-ones key (the sentinel).
- R5: Every accepted replace returns the largest unsigned key in the queue's contents just before the request. The new key joins the contents after that, even if it is larger than the key returned.
- R6: A replace with the key 0 works as a dequeue. After the sentinels are gone, DEPTH such replaces return the stored keys in non-increasing order.
- R7: A cycle with `req_valid` low leaves the queue contents unchanged and gives `top_valid` low on the next cycle.
- R8: Equal keys are never swapped with each other. Duplicate keys are each returned once, the same number of times they were inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Replace request present |
| req_ready | output | 1 | Block can take a request (high out of reset) |
| req_key | input | KEY_W | Key to insert |
| top_valid | output | 1 | `top_key` holds the key removed by the previous accepted request |
| top_key | output | KEY_W | Removed (largest) key |

## Verification
The hardest case to reach is when several keys are still moving down the row at once. A key newly written at the head moves at most two slots per cycle, so back-to-back replaces leave the row only partly sorted while the next request already depends on the head. The bench reaches this state in three ways: it issues long uninterrupted runs of pseudo-random, ascending and duplicate-heavy keys; it ends with a full drain of zero keys; and it compares each returned key against a plain multiset model of the queue contents.

// File: rtl/pq_pkg.sv
package pq_pkg;

    localparam int unsigned KEY_W_DEF = 32;
    localparam int unsigned DEPTH_DEF = 16;

    // Phase of the reorder wave in which a pair is compared.
    typedef enum logic {
        WAVE_EVEN = 1'b0,   // pairs (2k, 2k+1)
        WAVE_ODD  = 1'b1    // pairs (2k+1, 2k+2)
    } wave_e;

    // Number of compare-and-swap units in each wave for a row of n slots.
    function automatic int unsigned pairs_in_wave(input int unsigned n, input wave_e w);
        if (w == WAVE_EVEN) return n / 2;
        else                return (n - 1) / 2;
    endfunction

endpackage

// File: rtl/pq_cas.sv
module pq_cas #(
    parameter int unsigned KEY_W = pq_pkg::KEY_W_DEF
) (
    input  logic [KEY_W-1:0] up_in,    // lower index
    input  logic [KEY_W-1:0] dn_in,    // higher index
    output logic [KEY_W-1:0] up_out,
    output logic [KEY_W-1:0] dn_out
);
    logic swap;

    // Strictly greater: equal keys stay put (R8).
    assign swap   = dn_in > up_in;
    assign up_out = swap ? dn_in : up_in;
    assign dn_out = swap ? up_in : dn_in;

endmodule

// File: rtl/pq_row.sv
module pq_row #(
    parameter int unsigned KEY_W = pq_pkg::KEY_W_DEF,
    parameter int unsigned DEPTH = pq_pkg::DEPTH_DEF
) (
    input  logic [DEPTH-1:0][KEY_W-1:0] row_in,
    output logic [DEPTH-1:0][KEY_W-1:0] row_out
);
    import pq_pkg::*;

    localparam int unsigned N_EVEN = pairs_in_wave(DEPTH, WAVE_EVEN);
    localparam int unsigned N_ODD  = pairs_in_wave(DEPTH, WAVE_ODD);

    logic [DEPTH-1:0][KEY_W-1:0] mid;

    // First wave: slot 2k against slot 2k+1.
    generate
        for (genvar k = 0; k < N_EVEN; k++) begin : g_even
            pq_cas #(.KEY_W(KEY_W)) u_cas (
                .up_in (row_in[2*k]),
                .dn_in (row_in[2*k+1]),
                .up_out(mid[2*k]),
                .dn_out(mid[2*k+1])
            );
        end
        if (DEPTH % 2 == 1) begin : g_even_tail
            assign mid[DEPTH-1] = row_in[DEPTH-1];
        end
    endgenerate

    // Second wave: slot 2k+1 against slot 2k+2; slot 0 passes through.
    assign row_out[0] = mid[0];
    generate
        for (genvar k = 0; k < N_ODD; k++) begin : g_odd
            pq_cas #(.KEY_W(KEY_W)) u_cas (
                .up_in (mid[2*k+1]),
                .dn_in (mid[2*k+2]),
                .up_out(row_out[2*k+1]),
                .dn_out(row_out[2*k+2])
            );
        end
        if (DEPTH % 2 == 0) begin : g_odd_tail
            assign row_out[DEPTH-1] = mid[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/replace_pq.sv
module replace_pq #(
    parameter int unsigned KEY_W = pq_pkg::KEY_W_DEF,
    parameter int unsigned DEPTH = pq_pkg::DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [KEY_W-1:0] req_key,
    output logic             top_valid,
    output logic [KEY_W-1:0] top_key
);
    localparam logic [KEY_W-1:0] SENTINEL = {KEY_W{1'b1}};

    logic [DEPTH-1:0][KEY_W-1:0] slot_q;
    logic [DEPTH-1:0][KEY_W-1:0] seeded;
    logic [DEPTH-1:0][KEY_W-1:0] sorted;
    logic                        take;

    assign req_ready = ~rst;
    assign take      = req_valid & req_ready;

    // Overwrite the head with the incoming key before the two waves.
    always_comb begin
        seeded    = slot_q;
        seeded[0] = req_key;
    end

    pq_row #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_row (
        .row_in (seeded),
        .row_out(sorted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= SENTINEL;
            top_valid <= 1'b0;
            top_key   <= '0;
        end else begin
            top_valid <= take;
            if (take) begin
                slot_q  <= sorted;
                top_key <= slot_q[0];
            end
        end
    end

    // R1: the cycle after reset holds sentinels everywhere and no result.
    p_reset_fill_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot_q == {DEPTH{SENTINEL}}) && !top_valid);

    // R2: the result is the head as it was when the request was taken.
    p_top_is_old_head_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> top_valid && (top_key == $past(slot_q[0])));

    // R3: ready out of reset.
    p_ready_r3: assert property (@(posedge clk) !rst |-> req_ready);

    // R5: the head never falls below its neighbour after an update.
    p_head_order_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> slot_q[0] >= slot_q[1]);

    // R7: an idle cycle freezes the row and gives no result.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(slot_q) && !top_valid);

endmodule

// File: tb/tb_replace_pq.sv
module tb_replace_pq;
    localparam int unsigned W = 32;
    localparam int unsigned N = 16;
    localparam logic [W-1:0] INF = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [W-1:0] req_key;
    logic         top_valid;
    logic [W-1:0] top_key;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cycles = 0;
    logic [W-1:0] mdl [N];
    logic [W-1:0] lfsr = 32'h1234_5678;

    always #10 clk = ~clk;   // 50 MHz

    replace_pq #(.KEY_W(W), .DEPTH(N)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_key(req_key), .top_valid(top_valid), .top_key(top_key)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] next_rand(input logic [W-1:0] s);
        logic [W-1:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) mdl[i] = INF;
    endtask

    // Multiset model: take the largest key out, put the new key in its place.
    function automatic logic [W-1:0] model_replace(input logic [W-1:0] k);
        int best = 0;
        logic [W-1:0] v;
        for (int i = 1; i < N; i++) if (mdl[i] > mdl[best]) best = i;
        v = mdl[best];
        mdl[best] = k;
        return v;
    endfunction

    // Called at a falling edge; issues one request and checks its result at the next falling edge.
    task automatic replace(input logic [W-1:0] k, input string req);
        logic [W-1:0] exp = model_replace(k);
        req_valid = 1'b1;
        req_key   = k;
        @(negedge clk);
        check({req, " valid"}, {{(W-1){1'b0}}, top_valid}, 1);
        check(req, top_key, exp);
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        req_key   = '0;
    endtask

    task automatic t_reset();
        go_idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check("R1 top_valid after reset", {{(W-1){1'b0}}, top_valid}, 0);
        check("R3 ready out of reset", {{(W-1){1'b0}}, req_ready}, 1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < N; i++)
            replace(W'(100 + 7 * i), "R4 fill returns sentinel");
        go_idle();
    endtask

    task automatic t_idle();
        go_idle();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 idle gives no result", {{(W-1){1'b0}}, top_valid}, 0);
        end
        // Contents must be untouched: the next result follows the model.
        replace(W'(50), "R7 state held over idle");
        go_idle();
        @(negedge clk);
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 200; i++) begin
            lfsr = next_rand(lfsr);
            replace(lfsr, "R5 random back-to-back");
        end
        for (int i = 0; i < 40; i++)
            replace(W'(i * 1000), "R3 ascending back-to-back");
        go_idle();
        @(negedge clk);
    endtask

    task automatic t_dup();
        for (int i = 0; i < 60; i++)
            replace(W'(5 + (i % 3)), "R8 duplicate keys");
        go_idle();
    endtask

    task automatic t_drain();
        logic [W-1:0] prev = INF;
        for (int i = 0; i < N; i++) begin
            replace('0, "R6 dequeue by zero key");
            checks++;
            if (top_key > prev) begin
                errors++;
                $display("FAIL R6 order: actual %h expected at most %h", top_key, prev);
            end
            prev = top_key;
        end
        go_idle();
    endtask

    task automatic t_mid_reset();
        replace(W'(9), "R5 before reset");
        go_idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1 top_valid cleared", {{(W-1){1'b0}}, top_valid}, 0);
        replace(W'(3), "R1 sentinel after reset");
        go_idle();
    endtask

    initial begin
        rst = 1'b1;
        go_idle();
        @(negedge clk);
        t_reset();
        t_fill();
        t_idle();
        t_mixed();
        t_dup();
        t_drain();
        t_mid_reset();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule